// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave end of a three-wire serial memory with a 256 x 16 word array. A host raises chip select (`cs`), toggles the serial clock (`sk`) and shifts command bits in on `di`. The block answers on `do_o`, and `do_oe` is its tri-state enable. All three inputs are sampled on the system clock `clk`, and a rising edge of `sk` is found by comparing `sk` with its value one cycle earlier.

Every frame has the same header. The first `di`=1 seen on an `sk` rising edge while `cs` is high is the start bit. Two opcode bits follow, then eight address bits, most significant first. A write-enable latch protects the array from stray writes. Writes do not happen at once: they land when `cs` drops and are then followed by a busy period of fixed length. While that period runs, the host can poll the block's state on `do_o`. Lowering `cs` partway through a frame abandons a read at any point. It abandons a write only before a fixed edge of the frame.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Opcode 10 is a read. After the 11th `sk` rising edge of the frame (the last address bit), `do_o` drives a dummy 0. Each of the following 16 rising edges then presents the next bit of the addressed word, most significant bit first.
- R2: After reset the write-enable latch is clear. While the latch is clear, WRITE and write-all frames leave the array untouched and start no busy period.
- R3: Opcode 00 with address bits [7:6] = 11 sets the write-enable latch. Opcode 00 with address bits [7:6] = 00 clears it. Address bits [5:0] have no effect on either command.
- R4: A read returns stored data whether the write-enable latch is set or clear.
- R5: Opcode 01 is WRITE. The 16 data bits that follow the address, most significant first, are stored at the addressed word when `cs` falls after the frame.
- R6: Opcode 00 with address bits [7:6] = 01 is write-all. Its 16-bit data word is stored in all 256 words in one write cycle.
- R7: If `cs` falls before the 27th `sk` rising edge of a WRITE frame, the array is left unchanged and no busy period starts. From the 27th edge on, the write is committed.
- R8: Lowering `cs` at any point in a read frame ends the read. The next frame is decoded normally.
- R9: A committed write starts a busy period of `WR_CYCLES` clock cycles when `cs` falls. While `cs` is high, `do_o` shows 0 during that period and 1 once it ends. Frames begun during the busy period are ignored.
- R10: `do_oe` is 0 whenever `cs` is low. After reset, and after a frame that launched no write, `do_oe` stays 0 until a read reaches its dummy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models power-on |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out or ready/busy status |
| do_oe | output | 1 | Output enable for do_o |

## Verification
A bad bit counter shows up on the very next read: the dummy 0 and the 16 data bits come out shifted against the edges where they are expected. A write-enable latch or commit flag in the wrong state changes what a read returns. It also changes whether a ready/busy status appears as soon as `cs` is raised again after the frame. A busy counter that runs long or short changes how many cycles pass before `do_o` turns 1. Frames sent during the busy period expose a counter that does not block new starts, because the data read back afterwards is wrong.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int WR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HDR    = 3 + ADDR_W;
  localparam int FRAME  = HDR + DATA_W;
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);
  localparam int SR_W   = (ADDR_W + 2 > DATA_W) ? ADDR_W + 2 : DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              sk_q, wen_q, pend_q, all_q, rd_q, stat_q, dout_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SR_W-1:0]   sreg_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, obuf_q;
  logic [BUSY_W-1:0] busy_q;

  wire               sk_rise  = sk & ~sk_q;
  wire               edge_ok  = cs & sk_rise & (busy_q == '0);
  wire [SR_W-1:0]    nxt_sreg = {sreg_q[SR_W-2:0], di};
  wire [1:0]         nxt_op   = nxt_sreg[ADDR_W+1:ADDR_W];
  wire [ADDR_W-1:0]  nxt_addr = nxt_sreg[ADDR_W-1:0];
  wire               at_hdr   = cnt_q == CNT_W'(HDR - 1);
  wire               at_last  = cnt_q == CNT_W'(FRAME - 1);
  wire [1:0]         sel      = addr_q[ADDR_W-1:ADDR_W-2];
  wire               is_wr    = (op_q == 2'b01) | (op_q == 2'b00 && sel == 2'b01);
  wire               launch   = ~cs & pend_q;

  assign do_o  = rd_q ? dout_q : (busy_q == '0);
  assign do_oe = cs & (rd_q | stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0; wen_q <= 1'b0; pend_q <= 1'b0; all_q <= 1'b0;
      rd_q <= 1'b0; stat_q <= 1'b0; dout_q <= 1'b0;
      cnt_q <= '0; sreg_q <= '0; op_q <= '0; addr_q <= '0;
      wdata_q <= '0; obuf_q <= '0; busy_q <= '0;
    end else begin
      sk_q <= sk;
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (!cs) begin
        cnt_q <= '0;
        rd_q  <= 1'b0;
        if (pend_q) begin
          pend_q <= 1'b0;
          stat_q <= 1'b1;
          busy_q <= BUSY_W'(WR_CYCLES);
        end
      end else if (edge_ok) begin
        if (cnt_q == '0) begin
          if (di) begin
            cnt_q  <= 1;
            stat_q <= 1'b0;
            sreg_q <= '0;
          end
        end else if (cnt_q < CNT_W'(FRAME)) begin
          cnt_q  <= cnt_q + 1'b1;
          sreg_q <= nxt_sreg;
          if (at_hdr) begin
            op_q   <= nxt_op;
            addr_q <= nxt_addr;
            if (nxt_op == 2'b10) begin
              rd_q   <= 1'b1;
              dout_q <= 1'b0;
              obuf_q <= mem[nxt_addr];
            end
            if (nxt_op == 2'b00 && nxt_addr[ADDR_W-1:ADDR_W-2] == 2'b11) wen_q <= 1'b1;
            if (nxt_op == 2'b00 && nxt_addr[ADDR_W-1:ADDR_W-2] == 2'b00) wen_q <= 1'b0;
          end else if (rd_q) begin
            dout_q <= obuf_q[DATA_W-1];
            obuf_q <= {obuf_q[DATA_W-2:0], 1'b0};
          end
          if (at_last && is_wr && wen_q) begin
            pend_q  <= 1'b1;
            all_q   <= (op_q == 2'b00);
            wdata_q <= nxt_sreg[DATA_W-1:0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (launch) begin
      if (all_q) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= wdata_q;
      end else begin
        mem[addr_q] <= wdata_q;
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic do_oe,
  input logic wen,
  input logic busy,
  input logic pend
);
  a_r10_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  a_r9_busy_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe) |-> !do_o);

  a_r3_latch_moves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen) |-> $past(cs));

  a_r2_launch_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (wen && !$past(cs)));

  a_r7_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> wen);
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .cs    (cs),
  .do_o  (do_o),
  .do_oe (do_oe),
  .wen   (wen_q),
  .busy  (busy_q != '0),
  .pend  (pend_q)
);

// File: tb/mw_eeprom_slave_tb_top.sv
module mw_eeprom_slave_tb_top;
  localparam int WRC = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int   n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(8), .DATA_W(16), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    return {1'b1, op, a, d};
  endfunction

  function automatic logic [15:0] pat(input int a);
    logic [7:0] b = 8'(a);
    return {b, ~b} ^ 16'h1F2E;
  endfunction

  task automatic frame(input logic [26:0] bits, input int n, output logic [15:0] rd, output logic dummy);
    rd = '0; dummy = 1'b1;
    @(negedge clk) cs = 1'b1; sk = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) di = bits[26-i]; sk = 1'b0;
      @(negedge clk) sk = 1'b1;
      @(negedge clk);
      if (i == 10) dummy = do_o;
      if (i >= 11) rd = {rd[14:0], do_o};
    end
    @(negedge clk) sk = 1'b0;
    @(negedge clk) cs = 1'b0; di = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [26:0] bits, input int n);
    logic [15:0] r; logic d;
    frame(bits, n, r, d);
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [15:0] v, output logic dummy);
    frame(mk(2'b10, a, 16'h0), 27, v, dummy);
  endtask

  task automatic wait_ready(output int k);
    @(negedge clk) cs = 1'b1;
    k = 0;
    while (!(do_oe && do_o) && k < 1000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic no_status(input string req);
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
    chk(do_oe == 1'b0, req, 32'(do_oe), 32'h0);
    cs = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v; logic d; int k;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(do_oe == 1'b0, "R10 reset hiz", 32'(do_oe), 32'h0);

    // R2: latch clear after reset, write-all ignored
    send(mk(2'b00, 8'b0100_0000, 16'h1234), 27);
    no_status("R2 no launch while disabled");

    // R3: enable with don't-care low bits
    send(mk(2'b00, 8'b1101_0110, 16'h0), 11);
    send(mk(2'b00, 8'b0110_1001, 16'hC3A5), 27);
    wait_ready(k);
    chk(k > 0, "R9 busy seen first", 32'(k), 32'h1);
    chk(k >= WRC - 3 && k <= WRC + 3, "R9 busy length", 32'(k), 32'(WRC));
    chk(k < 1000, "R3 enable took effect", 32'(k), 32'(WRC));

    rd_word(8'd0, v, d);
    chk(d == 1'b0, "R1 dummy zero", 32'(d), 32'h0);
    chk(v == 16'hC3A5, "R6 write-all word 0", 32'(v), 32'hC3A5);
    rd_word(8'd77, v, d);
    chk(v == 16'hC3A5, "R6 write-all word 77", 32'(v), 32'hC3A5);
    rd_word(8'd255, v, d);
    chk(v == 16'hC3A5, "R6 write-all word 255", 32'(v), 32'hC3A5);

    // R3 disable, then writes ignored and reads still work
    send(mk(2'b00, 8'b0010_1010, 16'h0), 11);
    send(mk(2'b01, 8'd9, 16'hFFFF), 27);
    no_status("R2 write ignored after disable");
    send(mk(2'b00, 8'b0111_1111, 16'h0F0F), 27);
    no_status("R2 write-all ignored after disable");
    rd_word(8'd9, v, d);
    chk(v == 16'hC3A5, "R4 read while disabled", 32'(v), 32'hC3A5);
    rd_word(8'd200, v, d);
    chk(v == 16'hC3A5, "R2 array untouched", 32'(v), 32'hC3A5);

    // R5: sweep all addresses
    send(mk(2'b00, 8'b1100_0000, 16'h0), 11);
    for (int a = 0; a < 256; a++) begin
      send(mk(2'b01, 8'(a), pat(a)), 27);
      wait_ready(k);
    end
    for (int a = 0; a < 256; a++) begin
      rd_word(8'(a), v, d);
      chk(v == pat(a), "R5 write/read sweep", 32'(v), 32'(pat(a)));
      chk(d == 1'b0, "R1 dummy bit", 32'(d), 32'h0);
    end

    // R7: abort boundary at the 27th edge
    send(mk(2'b01, 8'd3, 16'h0000), 26);
    no_status("R7 abort before edge 27");
    rd_word(8'd3, v, d);
    chk(v == pat(3), "R7 aborted write leaves data", 32'(v), 32'(pat(3)));
    send(mk(2'b01, 8'd3, 16'h0000), 27);
    wait_ready(k);
    chk(k > 0, "R7 committed write busy", 32'(k), 32'h1);
    rd_word(8'd3, v, d);
    chk(v == 16'h0000, "R7 committed write stored", 32'(v), 32'h0);

    // R9: frame during busy is ignored
    send(mk(2'b01, 8'd4, 16'hAAAA), 27);
    send(mk(2'b01, 8'd4, 16'h5555), 27);
    wait_ready(k);
    rd_word(8'd4, v, d);
    chk(v == 16'hAAAA, "R9 frame during busy ignored", 32'(v), 32'hAAAA);

    // R8: read abort then normal read
    send(mk(2'b10, 8'd5, 16'h0), 15);
    chk(do_oe == 1'b0, "R10 hiz after abort", 32'(do_oe), 32'h0);
    rd_word(8'd5, v, d);
    chk(v == pat(5), "R8 read after abort", 32'(v), 32'(pat(5)));
    chk(d == 1'b0, "R8 dummy after abort", 32'(d), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule